// File: doc/BRIEF.md
# AES Column Mixing Unit (Forward and Inverse)

This block applies the AES column-mixing transform, or its inverse, to one 32-bit state column of four bytes. A single mode input picks the direction for each column presented. Every output byte is the GF(2^8) sum (bitwise XOR) of the four input bytes, each scaled by a fixed field constant. Products are reduced modulo x^8 + x^4 + x^3 + x + 1.

Each constant multiply is built as a fixed XOR network on the eight input bits. The network is a short chain of multiply-by-two stages, and the powers the constant needs are XORed together. No lookup table is used. The forward direction uses the constant row 02 03 01 01 and the inverse uses 0E 0B 0D 09. Each later output row rotates its constants right by one byte.

A parameter places an optional output register with a valid flag after the mixing logic. With that register in place, the unit accepts a new column every cycle, and the direction can change from one column to the next. A round datapath uses it next to its byte-substitution and row-rotation logic.

Top module: `aes_colmix`

## Requirements
- R1: With mode 0 (forward), output byte i is 02·a(i) ^ 03·a(i+1) ^ 01·a(i+2) ^ 01·a(i+3), indices taken modulo 4. For example, output byte 0 is 2·a0 ^ 3·a1 ^ a2 ^ a3.
- R2: With mode 1 (inverse), output byte i is 0E·a(i) ^ 0B·a(i+1) ^ 0D·a(i+2) ^ 09·a(i+3), indices taken modulo 4.
- R3: Multiplying by 02 shifts the byte left by one and XORs in 0x1B when the original bit 7 was set. For example, forward column 80 00 00 00 gives 1b 80 80 9b, and inverse gives 41 ec da f7.
- R4: Byte a0 sits in bits [31:24] of both col_in and col_out, and a3 sits in bits [7:0]. For example, forward column 00 00 00 80 gives 80 80 9b 1b.
- R5: Forward column db 13 53 45 gives 8e 4d a1 bc.
- R6: Applying the inverse mode to any forward result returns the original column, and the converse also holds.
- R7: With the register stage present (REG_OUT=1), out_valid is in_valid delayed by one clock. col_out loads only in cycles where in_valid is 1 and holds its value otherwise.
- R8: Synchronous active-high reset clears out_valid and col_out to 0, even when in_valid is 1 during reset.
- R9: The mode is sampled together with each column. Consecutive columns with different modes each get their own transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Column on col_in is to be transformed this cycle |
| mode | input | 1 | 0 = forward mix, 1 = inverse mix |
| col_in | input | 32 | Input column, a0 in [31:24] |
| out_valid | output | 1 | col_out holds a fresh result |
| col_out | output | 32 | Transformed column, byte 0 in [31:24] |

## Verification
Two functions can fall in the same cycle: a change of direction and the acceptance of a new column, and also reset and an incoming valid column. The bench provokes the first by sending a forward column, then an inverse column, then a forward column on three consecutive clocks. Each registered result is compared with the value a bench-side field model gives for that column's own mode. It provokes the second by holding in_valid high with live data throughout reset, and then judges that out_valid and col_out are both zero.

// File: rtl/aes_colmix_pkg.sv
package aes_colmix_pkg;

    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_W     = BYTE_W * COL_BYTES;
    localparam int COEF_BITS = 4;                 // constants up to 0x0E need x^0..x^3
    localparam logic [BYTE_W-1:0] POLY_LOW = 8'h1B; // low byte of x^8+x^4+x^3+x+1

    typedef logic [BYTE_W-1:0] gf_byte_t;
    // element [COL_BYTES-1] is byte 0 (most significant)
    typedef gf_byte_t [COL_BYTES-1:0] column_t;

    typedef enum logic {
        MIX_FWD = 1'b0,
        MIX_INV = 1'b1
    } mix_mode_e;

    typedef struct packed {
        logic    valid;
        column_t col;
    } col_beat_t;

    function automatic gf_byte_t xtime(input gf_byte_t x);
        return {x[BYTE_W-2:0], 1'b0} ^ (x[BYTE_W-1] ? POLY_LOW : '0);
    endfunction

    function automatic gf_byte_t fwd_coef(input int j);
        case (j)
            0:       return 8'h02;
            1:       return 8'h03;
            default: return 8'h01;
        endcase
    endfunction

    function automatic gf_byte_t inv_coef(input int j);
        case (j)
            0:       return 8'h0E;
            1:       return 8'h0B;
            2:       return 8'h0D;
            default: return 8'h09;
        endcase
    endfunction

    function automatic gf_byte_t byte_at(input column_t c, input int i);
        return c[COL_BYTES-1-i];
    endfunction

    // behavioural reference used only by the checks
    function automatic gf_byte_t gf_mul_ref(input gf_byte_t k, input gf_byte_t x);
        gf_byte_t acc = '0;
        gf_byte_t p   = x;
        for (int b = 0; b < COEF_BITS; b++) begin
            if (k[b]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    function automatic column_t mix_ref(input column_t c, input logic inv);
        column_t  r;
        gf_byte_t acc;
        for (int i = 0; i < COL_BYTES; i++) begin
            acc = '0;
            for (int j = 0; j < COL_BYTES; j++)
                acc = acc ^ gf_mul_ref(inv ? inv_coef(j) : fwd_coef(j),
                                       byte_at(c, (i + j) % COL_BYTES));
            r[COL_BYTES-1-i] = acc;
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul
    import aes_colmix_pkg::*;
#(
    parameter gf_byte_t COEF = 8'h02
) (
    input  gf_byte_t din,
    output gf_byte_t dout
);

    // din * x^k for k = 0..COEF_BITS-1, each a fixed XOR rewiring of the last
    gf_byte_t pow_q [COEF_BITS];

    assign pow_q[0] = din;

    generate
        for (genvar k = 1; k < COEF_BITS; k++) begin : g_pow
            assign pow_q[k] = xtime(pow_q[k-1]);
        end
    endgenerate

    always_comb begin
        dout = '0;
        for (int k = 0; k < COEF_BITS; k++)
            if (COEF[k]) dout = dout ^ pow_q[k];
    end

endmodule

// File: rtl/colmix_row.sv
module colmix_row
    import aes_colmix_pkg::*;
#(
    parameter int ROW = 0
) (
    input  column_t   col_i,
    input  mix_mode_e mode_i,
    output gf_byte_t  byte_o
);

    gf_byte_t fwd_terms [COL_BYTES];
    gf_byte_t inv_terms [COL_BYTES];
    gf_byte_t fwd_sum;
    gf_byte_t inv_sum;

    generate
        for (genvar j = 0; j < COL_BYTES; j++) begin : g_term
            localparam int SRC = (ROW + j) % COL_BYTES;
            gf_const_mul #(.COEF(fwd_coef(j))) u_fwd (
                .din  (col_i[COL_BYTES-1-SRC]),
                .dout (fwd_terms[j])
            );
            gf_const_mul #(.COEF(inv_coef(j))) u_inv (
                .din  (col_i[COL_BYTES-1-SRC]),
                .dout (inv_terms[j])
            );
        end
    endgenerate

    always_comb begin
        fwd_sum = '0;
        inv_sum = '0;
        for (int j = 0; j < COL_BYTES; j++) begin
            fwd_sum = fwd_sum ^ fwd_terms[j];
            inv_sum = inv_sum ^ inv_terms[j];
        end
        byte_o = (mode_i == MIX_INV) ? inv_sum : fwd_sum;
    end

endmodule

// File: rtl/aes_colmix.sv
module aes_colmix
    import aes_colmix_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             mode,
    input  logic [COL_W-1:0] col_in,
    output logic             out_valid,
    output logic [COL_W-1:0] col_out
);

    mix_mode_e mode_e;
    column_t   col_src;
    column_t   mixed;

    assign mode_e  = mix_mode_e'(mode);
    assign col_src = column_t'(col_in);

    generate
        for (genvar r = 0; r < COL_BYTES; r++) begin : g_row
            colmix_row #(.ROW(r)) u_row (
                .col_i  (col_src),
                .mode_i (mode_e),
                .byte_o (mixed[COL_BYTES-1-r])
            );
        end

        if (REG_OUT) begin : g_reg
            col_beat_t beat_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    beat_q <= '0;
                end else begin
                    beat_q.valid <= in_valid;
                    if (in_valid) beat_q.col <= mixed;
                end
            end

            assign out_valid = beat_q.valid;
            assign col_out   = beat_q.col;

            // R7
            valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            // R7
            valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R7
            hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(col_out));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign col_out   = mixed;
        end
    endgenerate

    // R6
    fwd_undo_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_e == MIX_FWD) |-> (mix_ref(mixed, 1'b1) == col_src));
    // R6
    inv_undo_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_e == MIX_INV) |-> (mix_ref(mixed, 1'b0) == col_src));

endmodule

// File: tb/aes_colmix_bench.sv
module aes_colmix_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        mode;
    logic [31:0] col_in;
    logic        out_valid;
    logic [31:0] col_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    // {mode, input column, expected column}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b0, 32'hdb135345, 32'h8e4da1bc},  // R5
        {1'b0, 32'hf20a225c, 32'h9fdc589d},
        {1'b0, 32'h01010101, 32'h01010101},
        {1'b0, 32'hc6c6c6c6, 32'hc6c6c6c6},
        {1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6},
        {1'b0, 32'h2d26314c, 32'h4d7ebdf8},
        {1'b0, 32'h80000000, 32'h1b80809b},  // R3 R4
        {1'b0, 32'h00000080, 32'h80809b1b},  // R4
        {1'b0, 32'h00000000, 32'h00000000},
        {1'b1, 32'h8e4da1bc, 32'hdb135345},
        {1'b1, 32'h9fdc589d, 32'hf20a225c},
        {1'b1, 32'hd5d5d7d6, 32'hd4d4d4d5},
        {1'b1, 32'h4d7ebdf8, 32'h2d26314c},
        {1'b1, 32'h01010101, 32'h01010101},
        {1'b1, 32'h80000000, 32'h41ecdaf7}   // R3
    };

    aes_colmix u_aes_colmix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode),
        .col_in    (col_in),
        .out_valid (out_valid),
        .col_out   (col_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // independent field model: shift-and-add multiply
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [31:0] model(input logic inv, input logic [31:0] c);
        logic [7:0] a [4];
        logic [7:0] k [4];
        logic [31:0] r;
        for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
        if (inv) k = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
        else     k = '{8'h02, 8'h03, 8'h01, 8'h01};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] s = 8'h00;
            for (int j = 0; j < 4; j++) s = s ^ gmul(a[(i+j)%4], k[j]);
            r[31-8*i -: 8] = s;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic m, input logic [31:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        col_in   = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] held;
        logic [31:0] fwd;
        rst      = 1'b1;
        in_valid = 1'b1;
        mode     = 1'b0;
        col_in   = 32'hdb135345;

        // R8: reset together with a valid column
        repeat (3) @(negedge clk);
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 col_out", col_out, 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;

        // R1 R2 R3 R4 R5: vector table
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][64], VEC[v][63:32]);
            check(VEC[v][64] ? "R2 vector" : "R1 vector", col_out, VEC[v][31:0]);
            check("R7 out_valid after beat", {31'd0, out_valid}, 32'd1);
        end

        // R7: idle cycles hold the result and drop out_valid
        held = col_out;
        @(negedge clk);
        in_valid = 1'b0;
        mode     = 1'b1;
        col_in   = 32'h12345678;
        repeat (2) @(negedge clk);
        check("R7 hold col_out", col_out, held);
        check("R7 idle out_valid", {31'd0, out_valid}, 32'd0);

        // R9: direction changes on consecutive columns
        @(negedge clk);
        in_valid = 1'b1; mode = 1'b0; col_in = 32'hdb135345;
        @(negedge clk);
        check("R9 beat fwd", col_out, 32'h8e4da1bc);
        in_valid = 1'b1; mode = 1'b1; col_in = 32'h9fdc589d;
        @(negedge clk);
        check("R9 beat inv", col_out, 32'hf20a225c);
        in_valid = 1'b1; mode = 1'b0; col_in = 32'h00000080;
        @(negedge clk);
        check("R9 beat fwd again", col_out, 32'h80809b1b);
        check("R9 valid", {31'd0, out_valid}, 32'd1);
        in_valid = 1'b0;

        // R6 R1 R2: round trip on pseudo-random columns
        seed = 32'h1f2e3d4c;
        for (int n = 0; n < 24; n++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            send(1'b0, seed);
            fwd = col_out;
            check("R1 random fwd", fwd, model(1'b0, seed));
            send(1'b1, fwd);
            check("R6 round trip", col_out, seed);
            send(1'b1, seed);
            check("R2 random inv", col_out, model(1'b1, seed));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule